// File: doc/BRIEF.md
# Queued Input Capture Channel

This block is one channel of an input capture unit running in queue mode. Whenever an already qualified edge strobe arrives, it copies the free-running timer count into a capture register. If the capture register already holds a value, that value first moves into a holding register, so the two registers act as a two-deep queue of timestamps. Software drains the queue by reading the registers. A read strobe on either register marks it empty. A read of the holding register also snapshots a pulse-accumulator count into an accumulator holding register.

A no-overwrite control decides what happens when both registers hold unread data. With the control clear, the oldest timestamp is discarded and the queue keeps moving. With the control set, the new edge is dropped and a sticky overflow flag records the loss. Edge qualification, glitch filtering and the timer itself sit outside this block.

Top module: `icq_channel`

## Requirements
- R1: When `edge_stb` is high at a rising clock edge and the capture is not dropped, `cap_val` shows the `timer_val` of that edge from the next cycle on and `cap_full` is 1. Every capture is decided and applied in the cycle of its strobe.
- R2: With `no_ovw` = 0 and the capture register full, an edge moves the old `cap_val` into `hold_val`, sets `hold_full` and loads the new timer value. If the holding register was also full, its old content is lost and `ovf` does not change.
- R3: With `no_ovw` = 1 and the capture register empty, an edge loads only the capture register. `hold_val` and `hold_full` stay unchanged.
- R4: With `no_ovw` = 1, the capture register full and the holding register empty, an edge moves `cap_val` into `hold_val`, sets `hold_full` and loads the new timer value into `cap_val`.
- R5: With `no_ovw` = 1 and both registers full, an edge changes neither `cap_val`, `hold_val` nor either full flag, and it sets `ovf` to 1.
- R6: `ovf` stays 1 until a cycle with `ovf_clr` = 1 and no dropped edge clears it. If a drop and `ovf_clr` occur in the same cycle, `ovf` is 1.
- R7: `cap_rd` clears `cap_full` and `hold_rd` clears `hold_full` at the next edge. A read strobe in the same cycle as an edge takes effect before that edge is judged, so the read register counts as empty for that edge.
- R8: `hold_rd` copies `acc_cnt` into `acc_hold`, which is visible the next cycle. Without `hold_rd`, `acc_hold` keeps its value.
- R9: In a cycle without `edge_stb`, `cap_val` and `hold_val` keep their values whatever `timer_val` does.
- R10: After reset, `cap_val`, `hold_val`, `acc_hold`, `cap_full`, `hold_full` and `ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timer_val | input | TW (16) | Free-running timer count |
| edge_stb | input | 1 | Qualified input edge, one cycle per edge |
| no_ovw | input | 1 | 1 protects unread data from being overwritten |
| cap_rd | input | 1 | Capture register read strobe |
| hold_rd | input | 1 | Holding register read strobe; also latches the accumulator |
| acc_cnt | input | AW (8) | Pulse accumulator count |
| ovf_clr | input | 1 | Clears the overflow flag |
| cap_val | output | TW (16) | Newest captured timestamp |
| hold_val | output | TW (16) | Older queued timestamp |
| acc_hold | output | AW (8) | Accumulator count latched by the last holding read |
| cap_full | output | 1 | Capture register holds unread data |
| hold_full | output | 1 | Holding register holds unread data |
| ovf | output | 1 | Sticky flag: an edge was dropped under no-overwrite |

## Verification
The bench targets the boundary between shifting and dropping. An edge that arrives while both registers are full is tested with the no-overwrite control in each state. A design that confuses the two cases would either lose the oldest timestamp while the control is set, or stall the queue while it is clear. Read strobes are placed in the same cycle as edges. If a design judged the edge on the flags before the read, it would drop or mis-route that capture. The bench also puts a drop in the same cycle as an overflow clear; a design with the wrong priority would lose the overflow record. A long pseudo-random stretch checks, every cycle, that the accumulator snapshot moves only on a holding-register read.

// File: rtl/icq_pkg.sv
package icq_pkg;

   // what a cycle does to the two-deep timestamp queue
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_LOAD  = 2'd1,
      ACT_SHIFT = 2'd2,
      ACT_DROP  = 2'd3
   } icq_act_e;

endpackage

// File: rtl/icq_ctrl.sv
module icq_ctrl
   import icq_pkg::*;
(
   input  logic     edge_stb,
   input  logic     no_ovw,
   input  logic     cap_full,
   input  logic     hold_full,
   input  logic     cap_rd,
   input  logic     hold_rd,
   output icq_act_e act
);

   // reads in the same cycle take effect before the edge is judged
   logic cap_busy;
   logic hold_busy;

   assign cap_busy  = cap_full  & ~cap_rd;
   assign hold_busy = hold_full & ~hold_rd;

   always_comb begin
      if (!edge_stb)
         act = ACT_NONE;
      else if (!cap_busy)
         act = ACT_LOAD;
      else if (!hold_busy || !no_ovw)
         act = ACT_SHIFT;
      else
         act = ACT_DROP;
   end

endmodule

// File: rtl/icq_slot.sv
module icq_slot #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] din,
   input  logic         rd_clr,
   output logic [W-1:0] dout,
   output logic         full
);

   initial begin
      assert (W >= 2) else $error("icq_slot: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         full <= 1'b0;
      end else begin
         if (ld)
            dout <= din;
         if (ld)
            full <= 1'b1;
         else if (rd_clr)
            full <= 1'b0;
      end
   end

   AST_FULL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> full);                                             // R1
   AST_EMPTY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !ld) |=> !full);                               // R7
   AST_VALUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(dout));                                   // R9

endmodule

// File: rtl/icq_acc_latch.sv
module icq_acc_latch #(
   parameter int AW     = 8,
   parameter bit ACC_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          snap,
   input  logic [AW-1:0] cnt,
   output logic [AW-1:0] held
);

   initial begin
      assert (AW >= 1) else $error("icq_acc_latch: AW must be at least 1");
   end

   generate
      if (ACC_EN) begin : g_latch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               held <= '0;
            else if (snap)
               held <= cnt;
         end

         AST_ACC_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
            snap |=> (held == $past(cnt)));                     // R8
         AST_ACC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !snap |=> $stable(held));                           // R8
      end else begin : g_none
         logic acc_unused;
         assign acc_unused = ^{snap, cnt, clk, rst_n};
         assign held = '0;
      end
   endgenerate

endmodule

// File: rtl/icq_channel.sv
module icq_channel
   import icq_pkg::*;
#(
   parameter int TW     = 16,
   parameter int AW     = 8,
   parameter bit ACC_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] timer_val,
   input  logic          edge_stb,
   input  logic          no_ovw,
   input  logic          cap_rd,
   input  logic          hold_rd,
   input  logic [AW-1:0] acc_cnt,
   input  logic          ovf_clr,
   output logic [TW-1:0] cap_val,
   output logic [TW-1:0] hold_val,
   output logic [AW-1:0] acc_hold,
   output logic          cap_full,
   output logic          hold_full,
   output logic          ovf
);

   initial begin
      assert (TW >= 2 && TW <= 64) else $error("icq_channel: TW out of range");
      assert (AW >= 1 && AW <= 32) else $error("icq_channel: AW out of range");
   end

   icq_act_e act;
   logic     cap_ld;
   logic     hold_ld;

   icq_ctrl u_ctrl (
      .edge_stb  (edge_stb),
      .no_ovw    (no_ovw),
      .cap_full  (cap_full),
      .hold_full (hold_full),
      .cap_rd    (cap_rd),
      .hold_rd   (hold_rd),
      .act       (act)
   );

   assign cap_ld  = (act == ACT_LOAD) || (act == ACT_SHIFT);
   assign hold_ld = (act == ACT_SHIFT);

   icq_slot #(.W(TW)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (cap_ld),
      .din    (timer_val),
      .rd_clr (cap_rd),
      .dout   (cap_val),
      .full   (cap_full)
   );

   icq_slot #(.W(TW)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (hold_ld),
      .din    (cap_val),
      .rd_clr (hold_rd),
      .dout   (hold_val),
      .full   (hold_full)
   );

   icq_acc_latch #(.AW(AW), .ACC_EN(ACC_EN)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .snap  (hold_rd),
      .cnt   (acc_cnt),
      .held  (acc_hold)
   );

   // sticky overflow: a dropped edge wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (act == ACT_DROP)
         ovf <= 1'b1;
      else if (ovf_clr)
         ovf <= 1'b0;
   end

   AST_LOAD_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_stb && act != ACT_DROP) |=> (cap_val == $past(timer_val) && cap_full)); // R1
   AST_SHIFT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_SHIFT) |=> (hold_val == $past(cap_val) && hold_full));            // R2
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (no_ovw && hold_full && !hold_rd) |=> $stable(hold_val));                     // R3
   AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_DROP) |=> ($stable(cap_val) && $stable(hold_val) && ovf));        // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);                                                   // R6
   AST_DROP_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_DROP) |-> (no_ovw && cap_full && hold_full));                     // R5
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_stb |=> ($stable(cap_val) && $stable(hold_val)));                       // R9

endmodule

// File: tb/icq_channel_tb.sv
`timescale 1ns/1ps
module icq_channel_tb;

   localparam int TW = 16;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] timer_val = '0;
   logic          edge_stb = 1'b0;
   logic          no_ovw = 1'b0;
   logic          cap_rd = 1'b0;
   logic          hold_rd = 1'b0;
   logic [AW-1:0] acc_cnt = '0;
   logic          ovf_clr = 1'b0;
   logic [TW-1:0] cap_val;
   logic [TW-1:0] hold_val;
   logic [AW-1:0] acc_hold;
   logic          cap_full;
   logic          hold_full;
   logic          ovf;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // behavioural reference: a queue of unread stamps plus a pending-slot view
   int m_cap = 0, m_hold = 0, m_acc = 0;
   bit m_cf = 0, m_hf = 0, m_ovf = 0;

   always #5 clk = ~clk;

   icq_channel u_dut (
      .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .edge_stb(edge_stb),
      .no_ovw(no_ovw), .cap_rd(cap_rd), .hold_rd(hold_rd), .acc_cnt(acc_cnt),
      .ovf_clr(ovf_clr), .cap_val(cap_val), .hold_val(hold_val),
      .acc_hold(acc_hold), .cap_full(cap_full), .hold_full(hold_full), .ovf(ovf)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "cap_val",   int'(cap_val),   m_cap);
      chk(tag, "hold_val",  int'(hold_val),  m_hold);
      chk(tag, "acc_hold",  int'(acc_hold),  m_acc);
      chk(tag, "cap_full",  int'(cap_full),  int'(m_cf));
      chk(tag, "hold_full", int'(hold_full), int'(m_hf));
      chk(tag, "ovf",       int'(ovf),       int'(m_ovf));
   endtask

   // drive one cycle, advance the model at the edge, compare at the falling edge
   task automatic cyc(input string tag, input bit e, input bit nov, input bit crd,
                      input bit hrd, input bit ocl, input int tv, input int ac);
      bit dropped;
      bit free_cap, free_hold;
      edge_stb = e; no_ovw = nov; cap_rd = crd; hold_rd = hrd;
      ovf_clr = ocl; timer_val = TW'(tv); acc_cnt = AW'(ac);
      @(posedge clk);
      dropped   = 0;
      free_cap  = !m_cf || crd;
      free_hold = !m_hf || hrd;
      if (hrd) m_acc = ac & 8'hFF;
      m_cf = !free_cap;
      m_hf = !free_hold;
      if (e) begin
         if (free_cap) begin
            m_cap = tv & 16'hFFFF; m_cf = 1;
         end else if (free_hold || !nov) begin
            m_hold = m_cap; m_hf = 1; m_cap = tv & 16'hFFFF;
         end else begin
            dropped = 1;
         end
      end
      if (dropped) m_ovf = 1;
      else if (ocl) m_ovf = 0;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit [15:0] lf;
      repeat (3) @(negedge clk);
      compare("R10");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R10");

      // R1: first capture, overwrite allowed
      cyc("R1", 1, 0, 0, 0, 0, 16'h1234, 0);
      // R9: idle with moving timer
      cyc("R9", 0, 0, 0, 0, 0, 16'h7777, 0);
      cyc("R9", 0, 1, 0, 0, 0, 16'h8888, 0);
      // R2: shift into empty hold, then overwrite both-full without overflow
      cyc("R2", 1, 0, 0, 0, 0, 16'h2222, 0);
      cyc("R2", 1, 0, 0, 0, 0, 16'h3333, 0);
      // R7 / R8: reads empty the queue, holding read latches accumulator
      cyc("R7", 0, 0, 1, 0, 0, 16'h0, 8'h11);
      cyc("R8", 0, 0, 0, 1, 0, 16'h0, 8'h5A);
      cyc("R8", 0, 0, 0, 0, 0, 16'h0, 8'hC3);
      // R3: lock set, capture register empty
      cyc("R3", 1, 1, 0, 0, 0, 16'hA001, 0);
      // R4: lock set, hold empty -> shift
      cyc("R4", 1, 1, 0, 0, 0, 16'hA002, 0);
      // R5: both full -> drop, overflow
      cyc("R5", 1, 1, 0, 0, 0, 16'hA003, 0);
      cyc("R6", 0, 1, 0, 0, 0, 16'h0, 0);
      // R6: drop and clear in the same cycle keeps the flag
      cyc("R6", 1, 1, 0, 0, 1, 16'hA004, 0);
      cyc("R6", 0, 1, 0, 0, 1, 16'h0, 0);
      // R7: capture read in the edge cycle -> load only
      cyc("R7", 1, 1, 1, 0, 0, 16'hB001, 0);
      // R7: holding read in the edge cycle -> shift, accumulator latched
      cyc("R7", 1, 1, 0, 1, 0, 16'hB002, 8'h77);
      // R2: both full, lock clear -> overwrite oldest, ovf stays 0
      cyc("R2", 1, 0, 0, 0, 0, 16'hB003, 0);

      // mixed traffic
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         cyc("R7", lf[0] | lf[5], lf[9], lf[1] & lf[2], lf[3] & lf[4],
             lf[6] & lf[7] & lf[8], int'(lf), int'(lf[15:8]));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule